// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command state machine of a parallel NOR flash. It watches write cycles on the host bus and recognises keyed, multi-cycle command sequences: a two-write unlock, then a command code, and for some commands further cycles. From these sequences it moves between array read, identifier (autoselect) read, CFI query, secured-region access, unlock bypass and erase-suspended read. It also issues one-clock request pulses for program, chip erase, sector erase, erase suspend and erase resume, with the address and data of the cycle that triggered them.

The embedded program and erase algorithms live outside this block. A `busy` input from that engine stands in for them: while it is high, command writes are ignored except the suspend code. Word and byte bus widths are selected by `byte_mode`, which changes the key addresses of the unlock cycles. In identifier mode a small read port returns fixed identification words selected by a word offset.

Top module: `flcmd_decoder`

## Requirements
- R1: After reset the mode output is 0 (array read), all request pulses are low and `id_data` is 0. Mode codes: 0 read, 1 erase-suspended read, 2 identifier, 3 CFI query, 4 secured region, 5 unlock bypass.
- R2: An unlock is data AA to key address A then data 55 to key address B, with A=555h, B=2AAh in word mode and A=AAAh, B=555h in byte mode; a write that breaks a sequence returns it to idle, keeps the mode and issues no request.
- R3: Command codes use data bits 7..0 only; key addresses compare address bits 10..0 in word mode and 11..0 in byte mode, higher bits are ignored.
- R4: Unlock, A0h to address A, then any write gives a one-clock `pgm_req` in the cycle after that write, with `req_addr`/`req_data` taken from it.
- R5: Unlock, 80h to A, unlock, then 10h to A gives `chip_erase_req`; 30h to any address instead gives `sect_erase_req` carrying that address.
- R6: Unlock then 90h to A enters mode 2; there `id_data` at word offset 00h is the maker code, 01h/0Eh/0Fh the three device words, 03h is 0082h when the secured region is factory locked else 0002h, 02h is `sect_prot` in bit 0, any other offset 0; outside mode 2 `id_data` is 0.
- R7: Data 98h to the CFI key (055h word, 0AAh byte) enters mode 3, but only from mode 0 or mode 2.
- R8: F0h to any address returns to mode 0, or to mode 1 when an erase is suspended; it is not a reset when it is program data or while in mode 5.
- R9: Unlock then 20h to A enters mode 5; there A0h then any write programs, and 90h followed by 00h returns to mode 0.
- R10: Unlock then 88h to A enters mode 4; unlock, 90h to A, then 00h returns to mode 0.
- R11: B0h is accepted only while a sector erase is running and `busy` is high; it gives `susp_req` and mode 1.
- R12: 30h is a resume only in mode 1, giving `resume_req` and mode 0; while suspended, erase setup, bypass and secured-region codes are rejected.
- R13: While `busy` is high every write other than an accepted B0h is ignored.
- R14: At most one request is high in any cycle, each lasts exactly one clock, and `req_addr`/`req_data` hold between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects byte-mode key addresses |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Embedded algorithm running |
| sect_prot | input | 1 | Protect status of the addressed sector |
| rd_off | input | 8 | Identifier word offset |
| id_data | output | 16 | Identifier read data |
| mode | output | 3 | Current mode code |
| pgm_req | output | 1 | Program request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| susp_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| req_addr | output | AW | Address latched with the last request |
| req_data | output | 16 | Data latched with the last request |

## Verification
Mode and every request pulse are registered, so each is due in the clock after the edge that samples the write that completes a sequence, while `id_data` is combinational and follows `rd_off` within the same cycle. The bench drives each write on a falling edge, lets one rising edge sample it and checks at the next falling edge, so every check falls exactly one cycle after its stimulus. Pulse width is checked one further falling edge later, and identifier reads are checked a short delay after `rd_off` changes.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_ESUSP = 3'd1,
    MD_ASEL  = 3'd2,
    MD_CFI   = 3'd3,
    MD_SECR  = 3'd4,
    MD_BYP   = 3'd5
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3, SQ_SX, SQ_BPGM, SQ_BX
  } seq_e;

  localparam int KW = 12;

  localparam logic [7:0] OP_KEY1 = 8'hAA;
  localparam logic [7:0] OP_KEY2 = 8'h55;
  localparam logic [7:0] OP_ASEL = 8'h90;
  localparam logic [7:0] OP_PGM  = 8'hA0;
  localparam logic [7:0] OP_ERS  = 8'h80;
  localparam logic [7:0] OP_BYP  = 8'h20;
  localparam logic [7:0] OP_SECR = 8'h88;
  localparam logic [7:0] OP_RST  = 8'hF0;
  localparam logic [7:0] OP_CHIP = 8'h10;
  localparam logic [7:0] OP_SECT = 8'h30;
  localparam logic [7:0] OP_SUSP = 8'hB0;
  localparam logic [7:0] OP_CFI  = 8'h98;
  localparam logic [7:0] OP_EXIT = 8'h00;

  // Key address compare: word mode looks at 11 bits, byte mode at 12.
  function automatic logic key_hit(input logic [KW-1:0] a, input logic bm,
                                   input logic [KW-1:0] wkey, input logic [KW-1:0] bkey);
    return bm ? (a == bkey) : (a[KW-2:0] == wkey[KW-2:0]);
  endfunction

endpackage

// File: rtl/flcmd_key_cmp.sv
module flcmd_key_cmp
  import flcmd_pkg::*;
(
  input  logic [KW-1:0] addr_lo,
  input  logic          byte_mode,
  output logic          hit_k1,
  output logic          hit_k2,
  output logic          hit_cfi
);
  assign hit_k1  = key_hit(addr_lo, byte_mode, 12'h555, 12'hAAA);
  assign hit_k2  = key_hit(addr_lo, byte_mode, 12'h2AA, 12'h555);
  assign hit_cfi = key_hit(addr_lo, byte_mode, 12'h055, 12'h0AA);
endmodule

// File: rtl/flcmd_id_rom.sv
module flcmd_id_rom #(
  parameter logic [15:0] MAKER_CODE  = 16'h0001,
  parameter logic [15:0] DEV_WORD0   = 16'h227E,
  parameter logic [15:0] DEV_WORD1   = 16'h2236,
  parameter logic [15:0] DEV_WORD2   = 16'h2200,
  parameter logic        SECR_LOCKED = 1'b1
) (
  input  logic        en,
  input  logic [7:0]  off,
  input  logic        sect_prot,
  output logic [15:0] data
);
  logic [15:0] word;

  always_comb begin
    case (off)
      8'h00:   word = MAKER_CODE;
      8'h01:   word = DEV_WORD0;
      8'h0E:   word = DEV_WORD1;
      8'h0F:   word = DEV_WORD2;
      8'h02:   word = {15'd0, sect_prot};
      8'h03:   word = SECR_LOCKED ? 16'h0082 : 16'h0002;
      default: word = 16'h0000;
    endcase
  end

  assign data = en ? word : 16'h0000;
endmodule

// File: rtl/flcmd_decoder.sv
module flcmd_decoder
  import flcmd_pkg::*;
#(
  parameter int          AW          = 21,
  parameter logic [15:0] MAKER_CODE  = 16'h0001,
  parameter logic [15:0] DEV_WORD0   = 16'h227E,
  parameter logic [15:0] DEV_WORD1   = 16'h2236,
  parameter logic [15:0] DEV_WORD2   = 16'h2200,
  parameter logic        SECR_LOCKED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          busy,
  input  logic          sect_prot,
  input  logic [7:0]    rd_off,
  output logic [15:0]   id_data,
  output logic [2:0]    mode,
  output logic          pgm_req,
  output logic          chip_erase_req,
  output logic          sect_erase_req,
  output logic          susp_req,
  output logic          resume_req,
  output logic [AW-1:0] req_addr,
  output logic [15:0]   req_data
);

  mode_e mode_q, mode_n;
  seq_e  seq_q, seq_n;
  logic  susp_q, erase_act_q, busy_q;
  logic  pgm_n, cer_n, ser_n, sus_n, res_n;
  logic  hit_k1, hit_k2, hit_cfi;

  // Named internal events for the checker
  logic       cmd_ok, susp_hit, busy_fall, any_req;
  logic [7:0] op;
  mode_e      base_mode;

  assign op        = wr_data[7:0];
  assign cmd_ok    = wr_en && !busy;
  assign susp_hit  = wr_en && busy && (op == OP_SUSP) && erase_act_q && !susp_q;
  assign busy_fall = busy_q && !busy;
  assign base_mode = susp_q ? MD_ESUSP : MD_READ;
  assign any_req   = pgm_n | cer_n | ser_n | sus_n | res_n;

  flcmd_key_cmp u_keys (
    .addr_lo  (wr_addr[KW-1:0]),
    .byte_mode(byte_mode),
    .hit_k1   (hit_k1),
    .hit_k2   (hit_k2),
    .hit_cfi  (hit_cfi)
  );

  flcmd_id_rom #(
    .MAKER_CODE (MAKER_CODE),
    .DEV_WORD0  (DEV_WORD0),
    .DEV_WORD1  (DEV_WORD1),
    .DEV_WORD2  (DEV_WORD2),
    .SECR_LOCKED(SECR_LOCKED)
  ) u_rom (
    .en       (mode_q == MD_ASEL),
    .off      (rd_off),
    .sect_prot(sect_prot),
    .data     (id_data)
  );

  always_comb begin
    mode_n = mode_q;
    seq_n  = seq_q;
    pgm_n  = 1'b0;
    cer_n  = 1'b0;
    ser_n  = 1'b0;
    sus_n  = 1'b0;
    res_n  = 1'b0;
    if (susp_hit) begin
      mode_n = MD_ESUSP;
      seq_n  = SQ_IDLE;
      sus_n  = 1'b1;
    end else if (cmd_ok) begin
      if (op == OP_RST && seq_q != SQ_PGM && seq_q != SQ_BPGM && mode_q != MD_BYP) begin
        mode_n = base_mode;
        seq_n  = SQ_IDLE;
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            case (mode_q)
              MD_BYP: begin
                if (op == OP_PGM)       seq_n = SQ_BPGM;
                else if (op == OP_ASEL) seq_n = SQ_BX;
              end
              MD_ASEL: if (op == OP_CFI && hit_cfi) mode_n = MD_CFI;
              MD_CFI:  ;
              default: begin
                if (op == OP_KEY1 && hit_k1) seq_n = SQ_U1;
                else if (mode_q == MD_READ && op == OP_CFI && hit_cfi) mode_n = MD_CFI;
                else if (mode_q == MD_ESUSP && op == OP_SECT) begin
                  res_n  = 1'b1;
                  mode_n = MD_READ;
                end
              end
            endcase
          end
          SQ_U1: seq_n = (op == OP_KEY2 && hit_k2) ? SQ_U2 : SQ_IDLE;
          SQ_U2: begin
            seq_n = SQ_IDLE;
            if (hit_k1) begin
              if (mode_q == MD_SECR) begin
                if (op == OP_ASEL) seq_n = SQ_SX;
              end else begin
                case (op)
                  OP_ASEL: mode_n = MD_ASEL;
                  OP_PGM:  seq_n  = SQ_PGM;
                  OP_ERS:  if (!susp_q) seq_n  = SQ_E1;
                  OP_BYP:  if (!susp_q) mode_n = MD_BYP;
                  OP_SECR: if (!susp_q) mode_n = MD_SECR;
                  default: ;
                endcase
              end
            end
          end
          SQ_PGM, SQ_BPGM: begin
            seq_n = SQ_IDLE;
            pgm_n = 1'b1;
          end
          SQ_E1: seq_n = (op == OP_KEY1 && hit_k1) ? SQ_E2 : SQ_IDLE;
          SQ_E2: seq_n = (op == OP_KEY2 && hit_k2) ? SQ_E3 : SQ_IDLE;
          SQ_E3: begin
            seq_n = SQ_IDLE;
            if (op == OP_CHIP && hit_k1) cer_n = 1'b1;
            else if (op == OP_SECT)      ser_n = 1'b1;
          end
          SQ_SX, SQ_BX: begin
            seq_n = SQ_IDLE;
            if (op == OP_EXIT) mode_n = MD_READ;
          end
          default: seq_n = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q         <= MD_READ;
      seq_q          <= SQ_IDLE;
      susp_q         <= 1'b0;
      erase_act_q    <= 1'b0;
      busy_q         <= 1'b0;
      pgm_req        <= 1'b0;
      chip_erase_req <= 1'b0;
      sect_erase_req <= 1'b0;
      susp_req       <= 1'b0;
      resume_req     <= 1'b0;
      req_addr       <= '0;
      req_data       <= '0;
    end else begin
      mode_q         <= mode_n;
      seq_q          <= seq_n;
      busy_q         <= busy;
      pgm_req        <= pgm_n;
      chip_erase_req <= cer_n;
      sect_erase_req <= ser_n;
      susp_req       <= sus_n;
      resume_req     <= res_n;
      if (sus_n)      susp_q <= 1'b1;
      else if (res_n) susp_q <= 1'b0;
      if (ser_n)                     erase_act_q <= 1'b1;
      else if (busy_fall && !susp_q) erase_act_q <= 1'b0;
      if (any_req) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/flcmd_decoder_chk.sv
module flcmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       busy,
  input logic [7:0] op,
  input logic [2:0] mode,
  input logic       pgm_req,
  input logic       chip_erase_req,
  input logic       sect_erase_req,
  input logic       susp_req,
  input logic       resume_req,
  input logic       erase_act,
  input logic       susp_hit
);

  // R14
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_req, chip_erase_req, sect_erase_req, susp_req, resume_req}));

  // R14
  pgm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> !pgm_req);

  // R13
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !susp_hit) |=>
      ($stable(mode) && !pgm_req && !chip_erase_req && !sect_erase_req && !resume_req));

  // R11
  susp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> ($past(erase_act) && $past(busy) && mode == 3'd1));

  // R12
  resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> ($past(mode) == 3'd1 && mode == 3'd0));

  // R7
  cfi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && $past(mode) != 3'd3) |-> ($past(mode) == 3'd0 || $past(mode) == 3'd2));

  // R9
  byp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 3'd5 && mode != 3'd5) |-> ($past(wr_en) && $past(op) == 8'h00));

endmodule

bind flcmd_decoder flcmd_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .busy          (busy),
  .op            (op),
  .mode          (mode),
  .pgm_req       (pgm_req),
  .chip_erase_req(chip_erase_req),
  .sect_erase_req(sect_erase_req),
  .susp_req      (susp_req),
  .resume_req    (resume_req),
  .erase_act     (erase_act_q),
  .susp_hit      (susp_hit)
);

// File: tb/flcmd_decoder_bench.sv
module flcmd_decoder_bench;

  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          byte_mode = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          busy = 1'b0;
  logic          sect_prot = 1'b0;
  logic [7:0]    rd_off = '0;
  logic [15:0]   id_data;
  logic [2:0]    mode;
  logic          pgm_req, chip_erase_req, sect_erase_req, susp_req, resume_req;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flcmd_decoder #(.AW(AW)) u_flcmd_decoder (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .sect_prot(sect_prot),
    .rd_off(rd_off), .id_data(id_data), .mode(mode), .pgm_req(pgm_req),
    .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
    .susp_req(susp_req), .resume_req(resume_req),
    .req_addr(req_addr), .req_data(req_data)
  );

  // request bit order: 0 program, 1 chip erase, 2 sector erase, 3 suspend, 4 resume
  typedef struct packed {
    logic        bm;
    logic [11:0] a;
    logic [15:0] d;
    logic [2:0]  md;
    logic [4:0]  rq;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h555, 16'h00AA, 3'd0, 5'd0},
    '{1'b0, 12'h2AA, 16'h0055, 3'd0, 5'd0},
    '{1'b0, 12'h555, 16'h00A0, 3'd0, 5'd0},
    '{1'b0, 12'h100, 16'h1234, 3'd0, 5'd1},   // R4 program
    '{1'b0, 12'h555, 16'h00AA, 3'd0, 5'd0},
    '{1'b0, 12'h2AA, 16'h0055, 3'd0, 5'd0},
    '{1'b0, 12'h555, 16'h0090, 3'd2, 5'd0},   // R6 identifier
    '{1'b0, 12'h000, 16'h00F0, 3'd0, 5'd0},   // R8 reset
    '{1'b0, 12'h055, 16'h0098, 3'd3, 5'd0},   // R7 CFI word
    '{1'b0, 12'h123, 16'h00F0, 3'd0, 5'd0},
    '{1'b1, 12'hAAA, 16'h00AA, 3'd0, 5'd0},
    '{1'b1, 12'h555, 16'h0055, 3'd0, 5'd0},
    '{1'b1, 12'hAAA, 16'h0020, 3'd5, 5'd0},   // R9 bypass enter
    '{1'b1, 12'h000, 16'h00F0, 3'd5, 5'd0},   // R8 no reset in bypass
    '{1'b1, 12'h000, 16'h00A0, 3'd5, 5'd0},
    '{1'b1, 12'h123, 16'h00F0, 3'd5, 5'd1},   // R9 program, F0 as data
    '{1'b1, 12'h000, 16'h0090, 3'd5, 5'd0},
    '{1'b1, 12'h000, 16'h0000, 3'd0, 5'd0},   // R9 exit
    '{1'b0, 12'h555, 16'h00AA, 3'd0, 5'd0},
    '{1'b0, 12'h2AA, 16'h0055, 3'd0, 5'd0},
    '{1'b0, 12'h555, 16'h0088, 3'd4, 5'd0},   // R10 enter
    '{1'b0, 12'h555, 16'h00AA, 3'd4, 5'd0},
    '{1'b0, 12'h2AA, 16'h0055, 3'd4, 5'd0},
    '{1'b0, 12'h555, 16'h0090, 3'd4, 5'd0},
    '{1'b0, 12'h000, 16'h0000, 3'd0, 5'd0},   // R10 exit
    '{1'b0, 12'h555, 16'h00AA, 3'd0, 5'd0},
    '{1'b0, 12'h2AB, 16'h0055, 3'd0, 5'd0},   // R2 wrong key
    '{1'b0, 12'h555, 16'h0090, 3'd0, 5'd0},   // R2 aborted
    '{1'b0, 12'h555, 16'h00AA, 3'd0, 5'd0},
    '{1'b0, 12'h2AA, 16'h0055, 3'd0, 5'd0},
    '{1'b0, 12'h555, 16'h0080, 3'd0, 5'd0},
    '{1'b0, 12'h555, 16'h00AA, 3'd0, 5'd0},
    '{1'b0, 12'h2AA, 16'h0055, 3'd0, 5'd0},
    '{1'b0, 12'h555, 16'h0010, 3'd0, 5'd2},   // R5 chip erase
    '{1'b1, 12'h555, 16'h00AA, 3'd0, 5'd0},   // R2 word key in byte mode
    '{1'b1, 12'h0AA, 16'h0098, 3'd3, 5'd0},   // R7 CFI byte
    '{1'b1, 12'h000, 16'h00F0, 3'd0, 5'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] reqs();
    return {resume_req, susp_req, sect_erase_req, chip_erase_req, pgm_req};
  endfunction

  // Called at a falling edge; returns at the next falling edge with results due.
  task automatic wr(input logic bm, input logic [AW-1:0] a, input logic [15:0] d);
    byte_mode = bm;
    wr_addr   = a;
    wr_data   = d;
    wr_en     = 1'b1;
    @(negedge clk);
    wr_en     = 1'b0;
  endtask

  task automatic unlock();
    wr(1'b0, 21'h555, 16'h00AA);
    wr(1'b0, 21'h2AA, 16'h0055);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode", mode, 0);
    check("R1 reqs", reqs(), 0);
    check("R1 id_data", id_data, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].bm, {9'd0, VEC[i].a}, VEC[i].d);
      check($sformatf("R2..R10 vec%0d mode", i), mode, VEC[i].md);
      check($sformatf("R2..R10 vec%0d reqs", i), reqs(), VEC[i].rq);
    end

    // R3: upper address and data bits ignored in command cycles
    wr(1'b0, 21'h1FF555, 16'hFFAA);
    wr(1'b0, 21'h0AB2AA, 16'h7755);
    wr(1'b0, 21'h100555, 16'hC390);
    check("R3 upper bits ignored", mode, 2);

    // R6: identifier reads
    sect_prot = 1'b1;
    rd_off = 8'h00; #1 check("R6 maker", id_data, 16'h0001);
    rd_off = 8'h01; #1 check("R6 dev0", id_data, 16'h227E);
    rd_off = 8'h0E; #1 check("R6 dev1", id_data, 16'h2236);
    rd_off = 8'h0F; #1 check("R6 dev2", id_data, 16'h2200);
    rd_off = 8'h03; #1 check("R6 secured lock", id_data, 16'h0082);
    rd_off = 8'h02; #1 check("R6 protected", id_data, 16'h0001);
    sect_prot = 1'b0; #1 check("R6 unprotected", id_data, 16'h0000);
    rd_off = 8'h05; #1 check("R6 other offset", id_data, 16'h0000);
    rd_off = 8'h00;
    @(negedge clk);

    // R7: CFI from identifier mode, then R8 exit
    wr(1'b0, 21'h055, 16'h0098);
    check("R7 cfi from id", mode, 3);
    #1 check("R6 id_data outside id mode", id_data, 0);
    wr(1'b0, 21'h000, 16'h00F0);
    check("R8 cfi exit", mode, 0);

    // R5: sector erase with address
    unlock();
    wr(1'b0, 21'h555, 16'h0080);
    unlock();
    wr(1'b0, 21'h12345, 16'h0030);
    check("R5 sector erase req", reqs(), 5'b00100);
    check("R5 sector addr", req_addr, 21'h12345);
    check("R5 sector data", req_data[7:0], 8'h30);
    @(negedge clk);
    check("R14 pulse one clock", reqs(), 0);
    check("R14 addr held", req_addr, 21'h12345);

    // R13: busy blocks commands
    busy = 1'b1;
    unlock();
    wr(1'b0, 21'h555, 16'h0090);
    check("R13 busy ignores id entry", mode, 0);
    check("R13 busy no request", reqs(), 0);

    // R11: suspend during sector erase
    wr(1'b0, 21'h000, 16'h00B0);
    check("R11 suspend req", reqs(), 5'b01000);
    check("R11 suspend mode", mode, 1);
    busy = 1'b0;
    @(negedge clk);

    // R12: erase setup rejected while suspended
    unlock();
    wr(1'b0, 21'h555, 16'h0080);
    check("R12 erase setup rejected mode", mode, 1);
    unlock();
    wr(1'b0, 21'h555, 16'h0010);
    check("R12 no chip erase while suspended", reqs(), 0);

    // R7: no CFI from suspended read
    wr(1'b0, 21'h055, 16'h0098);
    check("R7 cfi rejected in suspend", mode, 1);

    // R8: identifier while suspended, F0 back to suspended read
    unlock();
    wr(1'b0, 21'h555, 16'h0090);
    check("R6 id in suspend", mode, 2);
    wr(1'b0, 21'h000, 16'h00F0);
    check("R8 reset to suspend read", mode, 1);

    // R12: resume
    wr(1'b0, 21'h000, 16'h0030);
    check("R12 resume req", reqs(), 5'b10000);
    check("R12 resume mode", mode, 0);

    // erase finishes
    busy = 1'b1;
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);

    // R12: 30 in read mode is not a resume
    wr(1'b0, 21'h000, 16'h0030);
    check("R12 no resume in read", reqs(), 0);

    // R11: B0 with no sector erase running
    busy = 1'b1;
    wr(1'b0, 21'h000, 16'h00B0);
    check("R11 no suspend when idle", reqs(), 0);
    check("R11 mode kept", mode, 0);
    busy = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule